// File: doc/BRIEF.md
# GPIO Interrupt Status Controller

This block turns activity on a bank of general-purpose input pins into interrupt status and one shared interrupt line. Every pin owns a 32-bit word that holds its trigger configuration, its enables and its latched status. Each pin can be set to react to a level or to an edge, with a choice of active-high, active-low or either edge. A detected event can set an interrupt status bit, which needs the pin's interrupt enable. It can also set a wake status bit, which needs any of the pin's three wake-enable bits. Software clears a status bit by writing a one to it.

Pins are grouped in fours. A 46-bit summary vector shows which groups hold a pending pin, and it is read as two 32-bit words. The shared line `irq_o` rises when a new status appears while some pending pin is unmasked. An end-of-interrupt write silences the line until the next new status. A master register also holds a blocking window. When the window is enabled, changing any pin's debounce setting suspends status generation on every pin for a programmed number of cycles. The pin inputs are expected to arrive already synchronized and filtered.

Top module: `gpio_irq_stat`

## Requirements
- R1: After reset every pin word, both summary words and the master register read 0, and `irq_o` is low.
- R2: Pin p's word is at byte address 4p. Its fields are: bit 0 trigger (1 level, 0 edge), bits 2:1 polarity (00 high or rising, 01 low or falling, 10 both edges, 11 reserved), bit 3 interrupt enable, bit 4 unmask (1 unmasked), bits 7:5 wake enables, bits 11:8 debounce setting, bit 16 sampled pin level (read-only), bit 28 interrupt status and bit 29 wake status. Bits 11:0 read back as written. The read data comes with `rsp_valid_o` one cycle after the read is accepted.
- R3: In edge mode a status bit is set only on the selected transition. It stays set after the pin returns to its previous level.
- R4: In level mode the status bit is set in every cycle the active level is present, so it is set again one cycle after a clear while the level persists. Polarity 10 or 11 in level mode never sets status.
- R5: With interrupt enable at 0 the interrupt status is never set. An event sets the wake status whenever any wake-enable bit is 1.
- R6: Writing 1 to bit 28 or bit 29 clears that status, and a clear wins over a set in the same cycle. Writing 0 to either bit leaves it unchanged.
- R7: Summary bit k is the OR of the two status bits of pins 4k to 4k+3, whatever their mask. Bits 31:0 are read at byte address 0x300, and bits 45:32 are read at 0x304 in bits 13:0.
- R8: `irq_o` is high only when it is armed and at least one pending pin is unmasked. A pending masked pin alone does not drive it.
- R9: Writing 1 to bit 0 of the master register at 0x308 drops `irq_o` on the next cycle. The line stays low until some status bit is newly set.
- R10: Master bit 1 enables the blocking window and bits 27:16 set its length L in cycles. With it enabled, a pin write that changes bits 11:8 blocks status setting on every pin for the next L cycles, and during that time every pin's bit 3 reads 0.
- R11: Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | 184 | Synchronized pin levels |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always accepts) |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 10 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Shared interrupt line |

## Verification
A table walks every trigger and polarity combination across a before-and-after pin transition. It catches a design that latches edges in level mode, accepts the "both" setting in level mode, or lets a level status fail to re-latch after a clear. Directed tests cover a masked pending pin, which must appear in the summary but not on the line, and a line that must stay quiet after end-of-interrupt until a fresh status arrives. They also check that an edge arriving inside the blocking window is lost for good and that the enable bit reads 0 only during the window. Summary placement is checked at both ends of the vector, because a misplaced upper word would show up as a wrong bit 13 at 0x304.

// File: rtl/gpio_irq_stat_pkg.sv
package gpio_irq_stat_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned DB_W     = 4;
  localparam int unsigned EN_B     = 3;
  localparam int unsigned LVL_B    = 16;
  localparam int unsigned ISTS_B   = 28;
  localparam int unsigned WSTS_B   = 29;
  localparam int unsigned EOI_B    = 0;
  localparam int unsigned BLKEN_B  = 1;
  localparam int unsigned LEN_LSB  = 16;
  localparam int unsigned LEN_W    = 12;

  typedef enum logic [1:0] {
    ACT_HIGH = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_BOTH = 2'b10,
    ACT_RSVD = 2'b11
  } act_e;

  // packed msb..lsb so it maps onto pin word bits 11:0
  typedef struct packed {
    logic [DB_W-1:0] db;
    logic [2:0]      wake;
    logic            unmask;
    logic            en;
    act_e            act;
    logic            trig;
  } pin_cfg_t;

  localparam int unsigned CFG_W = $bits(pin_cfg_t);
endpackage

// File: rtl/gpio_irq_stat_pin.sv
module gpio_irq_stat_pin
  import gpio_irq_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              wr_i,
  input  pin_cfg_t          cfg_wr_i,
  input  logic              clr_int_i,
  input  logic              clr_wake_i,
  input  logic              block_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              pending_o,
  output logic              unmasked_o,
  output logic              new_o,
  output logic              db_chg_o
);
  pin_cfg_t cfg_q;
  logic prev_q, ists_q, wsts_q;
  logic rise, fall, match, evt, iset, wset, iclr, wclr;

  assign rise = pin_i & ~prev_q;
  assign fall = ~pin_i & prev_q;

  always_comb begin
    match = 1'b0;
    if (cfg_q.trig) begin
      unique case (cfg_q.act)
        ACT_HIGH: match = pin_i;
        ACT_LOW:  match = ~pin_i;
        default:  match = 1'b0;
      endcase
    end else begin
      unique case (cfg_q.act)
        ACT_HIGH: match = rise;
        ACT_LOW:  match = fall;
        ACT_BOTH: match = rise | fall;
        default:  match = 1'b0;
      endcase
    end
  end

  assign evt  = match & ~block_i;
  assign iset = evt & cfg_q.en;
  assign wset = evt & (|cfg_q.wake);
  assign iclr = wr_i & clr_int_i;
  assign wclr = wr_i & clr_wake_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      ists_q <= 1'b0;
      wsts_q <= 1'b0;
    end else begin
      if (wr_i) cfg_q <= cfg_wr_i;
      prev_q <= pin_i;
      ists_q <= iclr ? 1'b0 : (ists_q | iset);
      wsts_q <= wclr ? 1'b0 : (wsts_q | wset);
    end
  end

  assign new_o      = (iset & ~ists_q & ~iclr) | (wset & ~wsts_q & ~wclr);
  assign pending_o  = ists_q | wsts_q;
  assign unmasked_o = cfg_q.unmask;
  assign db_chg_o   = wr_i & (cfg_wr_i.db != cfg_q.db);

  always_comb begin
    rdata_o            = '0;
    rdata_o[CFG_W-1:0] = cfg_q;
    rdata_o[EN_B]      = cfg_q.en & ~block_i;
    rdata_o[LVL_B]     = prev_q;
    rdata_o[ISTS_B]    = ists_q;
    rdata_o[WSTS_B]    = wsts_q;
  end
endmodule

// File: rtl/gpio_irq_stat_blk.sv
module gpio_irq_stat_blk #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (start_i && len_i != '0)     cnt_q <= len_i;
    else if (cnt_q != '0)                cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/gpio_irq_stat_sum.sv
module gpio_irq_stat_sum #(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned GRP_SZ   = 4,
  localparam int unsigned NUM_GRP = NUM_PINS / GRP_SZ
) (
  input  logic [NUM_PINS-1:0] pending_i,
  input  logic [NUM_PINS-1:0] unmasked_i,
  output logic [NUM_GRP-1:0]  sum_o,
  output logic                any_up_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign sum_o[g] = |pending_i[g*GRP_SZ +: GRP_SZ];
  end

  assign any_up_o = |(pending_i & unmasked_i);
endmodule

// File: rtl/gpio_irq_stat_arm.sv
module gpio_irq_stat_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic new_i,
  input  logic eoi_i,
  input  logic any_up_i,
  output logic irq_o
);
  logic armed_q;

  // a fresh status wins over a coincident end-of-interrupt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (new_i) armed_q <= 1'b1;
    else if (eoi_i) armed_q <= 1'b0;
  end

  assign irq_o = armed_q & any_up_i;
endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat
  import gpio_irq_stat_pkg::*;
#(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned GRP_SZ   = 4,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] gpio_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [WORD_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [WORD_W-1:0]   rsp_rdata_o,
  output logic                irq_o
);
  localparam int unsigned NUM_GRP    = NUM_PINS / GRP_SZ;
  localparam int unsigned IDX_W      = ADDR_W - 2;
  localparam int unsigned SUM_LO_IDX = (1 << IDX_W) - 64;
  localparam int unsigned SUM_HI_IDX = SUM_LO_IDX + 1;
  localparam int unsigned MSTR_IDX   = SUM_LO_IDX + 2;

  logic [IDX_W-1:0]    word_idx;
  logic                aligned, wr_acc, rd_acc, mstr_wr, eoi;
  logic [NUM_PINS-1:0] pending, unmasked, new_vec, db_chg;
  logic [WORD_W-1:0]   pin_words [NUM_PINS];
  logic [NUM_GRP-1:0]  sum_w;
  logic [63:0]         sum_pad;
  logic                any_up, new_any, blk_active, blk_start;
  logic                blk_en_q;
  logic [LEN_W-1:0]    len_q;
  logic [WORD_W-1:0]   rd_mux, mstr_word;
  logic                rsp_valid_q;
  logic [WORD_W-1:0]   rsp_rdata_q;
  pin_cfg_t            cfg_wr;
  logic                unused_bits;

  assign req_ready_o = 1'b1;
  assign word_idx    = req_addr_i[ADDR_W-1:2];
  assign aligned     = (req_addr_i[1:0] == 2'b00);
  assign wr_acc      = req_valid_i & req_ready_o & req_write_i & aligned;
  assign rd_acc      = req_valid_i & req_ready_o & ~req_write_i;
  assign cfg_wr      = pin_cfg_t'(req_wdata_i[CFG_W-1:0]);
  assign unused_bits = ^req_wdata_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic sel;
    assign sel = wr_acc & (word_idx == IDX_W'(p));
    gpio_irq_stat_pin u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (gpio_i[p]),
      .wr_i       (sel),
      .cfg_wr_i   (cfg_wr),
      .clr_int_i  (req_wdata_i[ISTS_B]),
      .clr_wake_i (req_wdata_i[WSTS_B]),
      .block_i    (blk_active),
      .rdata_o    (pin_words[p]),
      .pending_o  (pending[p]),
      .unmasked_o (unmasked[p]),
      .new_o      (new_vec[p]),
      .db_chg_o   (db_chg[p])
    );
  end

  gpio_irq_stat_sum #(.NUM_PINS(NUM_PINS), .GRP_SZ(GRP_SZ)) u_sum (
    .pending_i  (pending),
    .unmasked_i (unmasked),
    .sum_o      (sum_w),
    .any_up_o   (any_up)
  );

  assign mstr_wr   = wr_acc & (word_idx == IDX_W'(MSTR_IDX));
  assign eoi       = mstr_wr & req_wdata_i[EOI_B];
  assign blk_start = blk_en_q & (|db_chg);
  assign new_any   = |new_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_en_q <= 1'b0;
      len_q    <= '0;
    end else if (mstr_wr) begin
      blk_en_q <= req_wdata_i[BLKEN_B];
      len_q    <= req_wdata_i[LEN_LSB +: LEN_W];
    end
  end

  gpio_irq_stat_blk #(.LEN_W(LEN_W)) u_blk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (blk_start),
    .len_i    (len_q),
    .active_o (blk_active)
  );

  gpio_irq_stat_arm u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .new_i    (new_any),
    .eoi_i    (eoi),
    .any_up_i (any_up),
    .irq_o    (irq_o)
  );

  assign sum_pad = 64'(sum_w);

  always_comb begin
    mstr_word                   = '0;
    mstr_word[BLKEN_B]          = blk_en_q;
    mstr_word[LEN_LSB +: LEN_W] = len_q;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (word_idx < IDX_W'(NUM_PINS))            rd_mux = pin_words[word_idx];
      else if (word_idx == IDX_W'(SUM_LO_IDX))    rd_mux = sum_pad[31:0];
      else if (word_idx == IDX_W'(SUM_HI_IDX))    rd_mux = sum_pad[63:32];
      else if (word_idx == IDX_W'(MSTR_IDX))      rd_mux = mstr_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
endmodule

// File: rtl/gpio_irq_stat_chk.sv
module gpio_irq_stat_chk #(
  parameter int unsigned NUM_GRP = 46
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_o,
  input logic [NUM_GRP-1:0] sum_i,
  input logic               any_up_i,
  input logic               eoi_i,
  input logic               new_i,
  input logic               blk_active_i,
  input logic               rd_i,
  input logic               rsp_valid_i
);
  // R8
  irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sum_i != '0));

  // R7
  unmasked_in_summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_up_i |-> (sum_i != '0));

  // R9
  eoi_quiets_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !new_i) |=> !irq_o);

  // R10
  no_new_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_active_i |-> !new_i);

  // R2
  rsp_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rsp_valid_i);

  // R2
  no_stray_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rsp_valid_i);
endmodule

bind gpio_irq_stat gpio_irq_stat_chk #(.NUM_GRP(NUM_GRP)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_o        (irq_o),
  .sum_i        (sum_w),
  .any_up_i     (any_up),
  .eoi_i        (eoi),
  .new_i        (new_any),
  .blk_active_i (blk_active),
  .rd_i         (rd_acc),
  .rsp_valid_i  (rsp_valid_o)
);

// File: tb/gpio_irq_stat_tb_top.sv
module gpio_irq_stat_tb_top;
  localparam int unsigned NP = 184;
  localparam logic [9:0] SUM_LO = 10'h300;
  localparam logic [9:0] SUM_HI = 10'h304;
  localparam logic [9:0] MSTR   = 10'h308;
  localparam int NVEC = 14;
  // {trig, act[1:0], pin_before, pin_after, expected int status}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0_00_011, 6'b0_00_100, 6'b0_01_101, 6'b0_01_010,
    6'b0_10_011, 6'b0_10_101, 6'b0_00_000,
    6'b1_00_011, 6'b1_00_111, 6'b1_00_101, 6'b1_01_101,
    6'b1_01_110, 6'b1_10_010, 6'b1_11_110
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] gpio = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  logic [31:0] rd_val;
  logic last_rsp_valid;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_irq_stat dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    last_rsp_valid = rsp_valid;
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(10'h000, rd_val); chk("R1 pin0 word", rd_val, 32'h0);
    rd(SUM_LO, rd_val);  chk("R1 summary lo", rd_val, 32'h0);
    rd(SUM_HI, rd_val);  chk("R1 summary hi", rd_val, 32'h0);
    rd(MSTR, rd_val);    chk("R1 master", rd_val, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 readback of all config fields, pin 100
    wr(10'h190, 32'h0000_0FFF);
    rd(10'h190, rd_val);
    chk("R2 cfg readback", rd_val, 32'h0000_0FFF);
    chk("R2 rsp valid", {31'h0, last_rsp_valid}, 32'h1);
    wr(10'h190, 32'h0);

    // R11 unmapped and misaligned
    rd(10'h3F0, rd_val); chk("R11 unmapped read", rd_val, 32'h0);
    wr(10'h191, 32'h0000_0FFF);
    rd(10'h191, rd_val); chk("R11 misaligned read", rd_val, 32'h0);
    rd(10'h190, rd_val); chk("R11 misaligned write ignored", rd_val, 32'h0);

    // R3 / R4 trigger table on pin 5
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] cfg;
      cfg = {27'h0, 1'b1, 1'b1, VEC[i][4:3], VEC[i][5]};
      gpio[5] = VEC[i][2];
      idle(2);
      wr(10'h014, cfg | 32'h3000_0000);
      idle(2);
      wr(10'h014, cfg | 32'h3000_0000);
      idle(2);
      gpio[5] = VEC[i][1];
      idle(3);
      rd(10'h014, rd_val);
      chk(VEC[i][5] ? "R4 level vector" : "R3 edge vector",
          {31'h0, rd_val[28]}, {31'h0, VEC[i][0]});
    end
    gpio[5] = 1'b0;
    wr(10'h014, 32'h3000_0000);
    idle(2);

    // R8 masked pending pin 16
    wr(10'h040, 32'h0000_0008);
    gpio[16] = 1'b1;
    idle(2);
    chk("R8 masked no irq", {31'h0, irq}, 32'h0);
    rd(SUM_LO, rd_val); chk("R8 summary ignores mask", rd_val, 32'h0000_0010);
    wr(10'h040, 32'h0000_0018);
    chk("R8 unmask raises irq", {31'h0, irq}, 32'h1);
    gpio[16] = 1'b0;
    wr(10'h040, 32'h3000_0000);
    chk("R8 clear drops irq", {31'h0, irq}, 32'h0);

    // R9 end-of-interrupt, pin 12
    wr(10'h030, 32'h0000_0018);
    gpio[12] = 1'b1;
    idle(1);
    chk("R9 irq on edge", {31'h0, irq}, 32'h1);
    wr(MSTR, 32'h0000_0001);
    chk("R9 eoi drops irq", {31'h0, irq}, 32'h0);
    idle(3);
    chk("R9 stays low while pending", {31'h0, irq}, 32'h0);
    gpio[12] = 1'b0;
    wr(10'h030, 32'h3000_0018);
    gpio[12] = 1'b1;
    idle(1);
    chk("R9 new status re-arms", {31'h0, irq}, 32'h1);
    gpio[12] = 1'b0;
    wr(10'h030, 32'h3000_0000);

    // R5 / R6 / R7 wake status on pin 20, interrupt disabled
    wr(10'h050, 32'h0000_0020);
    gpio[20] = 1'b1;
    idle(2);
    rd(10'h050, rd_val); chk("R5 wake set, int clear", {30'h0, rd_val[29:28]}, 32'h2);
    rd(SUM_LO, rd_val);  chk("R7 summary group 5", rd_val, 32'h0000_0020);
    wr(10'h050, 32'h0000_0020);
    rd(10'h050, rd_val); chk("R6 zero write keeps status", {31'h0, rd_val[29]}, 32'h1);
    wr(10'h050, 32'h2000_0020);
    rd(10'h050, rd_val); chk("R6 one write clears", {31'h0, rd_val[29]}, 32'h0);
    gpio[20] = 1'b0;
    wr(10'h050, 32'h0);

    // R7 upper summary word, pin 182 -> group 45
    wr(10'h2D8, 32'h0000_0008);
    gpio[182] = 1'b1;
    idle(2);
    rd(SUM_HI, rd_val); chk("R7 summary hi bit 13", rd_val, 32'h0000_2000);
    rd(SUM_LO, rd_val); chk("R7 summary lo empty", rd_val, 32'h0);
    gpio[182] = 1'b0;
    wr(10'h2D8, 32'h3000_0000);

    // R10 blocking window, length 20
    wr(MSTR, 32'h0014_0002);
    rd(MSTR, rd_val); chk("R10 master readback", rd_val, 32'h0014_0002);
    wr(10'h020, 32'h0000_0018);
    wr(10'h024, 32'h0000_0100);
    rd(10'h020, rd_val); chk("R10 enable reads 0 in window", rd_val, 32'h0000_0010);
    gpio[8] = 1'b1;
    idle(2);
    rd(10'h020, rd_val); chk("R10 edge lost in window", {31'h0, rd_val[28]}, 32'h0);
    chk("R10 no irq in window", {31'h0, irq}, 32'h0);
    idle(25);
    rd(10'h020, rd_val); chk("R10 enable back after window", rd_val, 32'h0001_0018);
    gpio[8] = 1'b0;
    idle(1);
    gpio[8] = 1'b1;
    idle(2);
    rd(10'h020, rd_val); chk("R10 edge after window", {31'h0, rd_val[28]}, 32'h1);
    chk("R10 irq after window", {31'h0, irq}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule